// File: doc/BRIEF.md
# Pattern Constant Fetch Unit

This unit carries out the pattern instruction of a small 4-bit controller. When the instruction starts, the unit builds a temporary 12-bit ROM address from the current program counter, the accumulator, the B register, the carry flag and a 3-bit operand. It reads one 10-bit constant word through a synchronous ROM port and sends the word's low eight bits to the accumulator and B pair, to the I/O register pair R2/R3, or to both. Two command bits inside the fetched word choose the destination.

The program counter is never overwritten by the temporary address. The instruction ends after exactly two cycles. The unit then reports the sequential successor of the original program counter. The ROM address is ordered, from the MSB, as a 1-bit bank, a 5-bit page and a 6-bit offset.

Top module: `pat_fetch_unit`

## Requirements
- R1: During the fetch cycle, rom_addr_o[5:0] equals {acc_i, b_i[1:0]}, with the accumulator in bits 5:2. These inputs are sampled on the clock edge that accepts start_i.
- R2: During the fetch cycle, rom_addr_o[10:6] equals pc_i[10:6] ORed with {p_i[1:0], carry_i, b_i[3:2]}.
- R3: During the fetch cycle, rom_addr_o[11] equals pc_i[11] OR p_i[2]. A program counter in bank 1 can therefore only reach bank 1.
- R4: rom_en_o is high for exactly the one cycle after start_i is accepted. The cycle after that is the capture cycle.
- R5: In the capture cycle, if rom_data_i[8] is 1, ab_we_o is high, acc_o is rom_data_i[3:0] and b_o is rom_data_i[7:4].
- R6: In the capture cycle, if rom_data_i[9] is 1, io_we_o is high, r2_o is rom_data_i[3:0] and r3_o is rom_data_i[7:4]. If both bits 8 and 9 are 1, both pairs are written.
- R7: If rom_data_i[9:8] is 00, or in any cycle that is not a capture cycle, neither write enable is high.
- R8: done_o and pc_we_o are high only in the capture cycle. In that cycle pc_next_o is the accepted pc_i plus one, modulo 4096.
- R9: start_i is ignored while busy_o is high. A fetch in progress keeps its address, and no second fetch follows it.
- R10: While rst_ni is low, and after it is released, busy_o, rom_en_o, done_o, pc_we_o and both write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a pattern fetch |
| pc_i | input | 12 | Current program counter {bank, page, offset} |
| acc_i | input | 4 | Accumulator |
| b_i | input | 4 | B register |
| carry_i | input | 1 | Carry flag |
| p_i | input | 3 | Instruction operand |
| rom_en_o | output | 1 | ROM read enable |
| rom_addr_o | output | 12 | ROM read address |
| rom_data_i | input | 10 | ROM word, valid the cycle after the read |
| ab_we_o | output | 1 | Write strobe for accumulator and B |
| acc_o | output | 4 | Accumulator write data |
| b_o | output | 4 | B write data |
| io_we_o | output | 1 | Write strobe for R2 and R3 |
| r2_o | output | 4 | R2 write data |
| r3_o | output | 4 | R3 write data |
| pc_we_o | output | 1 | Program counter update strobe |
| pc_next_o | output | 12 | Incremented program counter |
| done_o | output | 1 | Instruction complete |
| busy_o | output | 1 | Fetch in progress |

## Verification
start_i is sampled on edge E0. The read address and rom_en_o become valid after E0. The bench ROM model registers the word on E1, so the write strobes, routed data, done_o and pc_next_o are due after E1. busy_o falls after E2. The bench drives inputs on falling edges and samples each result on the falling edge that follows the rising edge where that result is due. This keeps every check half a period away from any register update.

// File: rtl/pat_fetch_pkg.sv
package pat_fetch_pkg;
  localparam int BANK_W = 1;
  localparam int PAGE_W = 5;
  localparam int NIB_W  = 4;
  localparam int OP_W   = 3;
  localparam int OFS_W  = NIB_W + 2;
  localparam int ADDR_W = BANK_W + PAGE_W + OFS_W;
  localparam int WORD_W = 2 * NIB_W + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_CAP} pat_st_e;
endpackage

// File: rtl/pat_addr_gen.sv
module pat_addr_gen
  import pat_fetch_pkg::*;
#(
  parameter int NW = NIB_W,
  parameter int PW = PAGE_W,
  parameter int OW = OP_W,
  localparam int AW = 1 + PW + NW + 2
) (
  input  logic [AW-1:0] pc_i,
  input  logic [NW-1:0] acc_i,
  input  logic [NW-1:0] b_i,
  input  logic          carry_i,
  input  logic [OW-1:0] p_i,
  output logic [AW-1:0] addr_o
);
  localparam int HI_W = PW + 1;
  logic [HI_W-1:0] hi_mod;

  // operand on top (its MSB hits the bank), then carry, then B high pair
  assign hi_mod = HI_W'({p_i, carry_i, b_i[NW-1 -: 2]});
  assign addr_o = {pc_i[AW-1 -: HI_W] | hi_mod, acc_i, b_i[1:0]};
endmodule

// File: rtl/pat_seq.sv
module pat_seq
  import pat_fetch_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  output logic    accept_o,
  output pat_st_e st_o
);
  pat_st_e st_q, st_d;

  assign accept_o = (st_q == ST_IDLE) && start_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_FETCH;
      ST_FETCH: st_d = ST_CAP;
      ST_CAP:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;

  assign st_o = st_q;

  assert_fetch_to_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FETCH) |=> (st_q == ST_CAP));
  assert_cap_to_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CAP) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/pat_route.sv
module pat_route
  import pat_fetch_pkg::*;
#(
  parameter int NW = NIB_W,
  localparam int WW = 2 * NW + 2
) (
  input  logic          cap_i,
  input  logic [WW-1:0] word_i,
  output logic [1:0]    we_o,
  output logic [NW-1:0] lo_o,
  output logic [NW-1:0] hi_o
);
  // command bit g (word bit 2*NW+g): g=0 acc/B pair, g=1 R2/R3 pair
  for (genvar g = 0; g < 2; g++) begin : g_dest
    assign we_o[g] = cap_i & word_i[2*NW+g];
  end
  assign lo_o = word_i[NW-1:0];
  assign hi_o = word_i[2*NW-1:NW];
endmodule

// File: rtl/pat_fetch_unit.sv
module pat_fetch_unit
  import pat_fetch_pkg::*;
#(
  parameter int NW = NIB_W,
  parameter int PW = PAGE_W,
  parameter int OW = OP_W,
  localparam int AW = 1 + PW + NW + 2,
  localparam int WW = 2 * NW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] pc_i,
  input  logic [NW-1:0] acc_i,
  input  logic [NW-1:0] b_i,
  input  logic          carry_i,
  input  logic [OW-1:0] p_i,
  output logic          rom_en_o,
  output logic [AW-1:0] rom_addr_o,
  input  logic [WW-1:0] rom_data_i,
  output logic          ab_we_o,
  output logic [NW-1:0] acc_o,
  output logic [NW-1:0] b_o,
  output logic          io_we_o,
  output logic [NW-1:0] r2_o,
  output logic [NW-1:0] r3_o,
  output logic          pc_we_o,
  output logic [AW-1:0] pc_next_o,
  output logic          done_o,
  output logic          busy_o
);
  pat_st_e       st;
  logic          accept;
  logic [AW-1:0] addr_d, addr_q, pc_q;
  logic [1:0]    we;
  logic [NW-1:0] lo, hi;

  pat_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .accept_o(accept),
    .st_o    (st)
  );

  pat_addr_gen #(.NW(NW), .PW(PW), .OW(OW)) u_addr (
    .pc_i   (pc_i),
    .acc_i  (acc_i),
    .b_i    (b_i),
    .carry_i(carry_i),
    .p_i    (p_i),
    .addr_o (addr_d)
  );

  // temporary address kept apart from the program counter copy
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      addr_q <= '0;
      pc_q   <= '0;
    end else if (accept) begin
      addr_q <= addr_d;
      pc_q   <= pc_i;
    end

  pat_route #(.NW(NW)) u_route (
    .cap_i (st == ST_CAP),
    .word_i(rom_data_i),
    .we_o  (we),
    .lo_o  (lo),
    .hi_o  (hi)
  );

  assign rom_en_o   = (st == ST_FETCH);
  assign rom_addr_o = addr_q;
  assign done_o     = (st == ST_CAP);
  assign busy_o     = (st != ST_IDLE);
  assign pc_we_o    = done_o;
  assign pc_next_o  = pc_q + AW'(1);
  assign ab_we_o    = we[0];
  assign io_we_o    = we[1];
  assign acc_o      = lo;
  assign b_o        = hi;
  assign r2_o       = lo;
  assign r3_o       = hi;

  assert_en_then_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en_o |=> done_o);
  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_bank_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_en_o && pc_q[AW-1]) |-> rom_addr_o[AW-1]);
  assert_we_in_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_we_o || io_we_o) |-> done_o);
  assert_addr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $stable(rom_addr_o));
endmodule

// File: tb/tb_pat_fetch_unit.sv
module tb_pat_fetch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {pc[11:0], acc[3:0], b[3:0], carry, p[2:0]}
  localparam logic [23:0] VECS [NV] = '{
    {12'h000, 4'h5, 4'b0001, 1'b0, 3'b000},
    {12'h0C3, 4'hA, 4'b0010, 1'b1, 3'b001},
    {12'h800, 4'hF, 4'b1111, 1'b0, 3'b000},
    {12'h040, 4'h3, 4'b0100, 1'b0, 3'b100},
    {12'hFFF, 4'h0, 4'b0011, 1'b1, 3'b111},
    {12'h7C0, 4'h9, 4'b1001, 1'b0, 3'b010}
  };

  logic clk = 0, rst_n = 0, start = 0, carry = 0;
  logic [11:0] pc = '0;
  logic [3:0]  acc = '0, b = '0;
  logic [2:0]  p = '0;
  logic        rom_en, ab_we, io_we, pc_we, done, busy;
  logic [11:0] rom_addr, pc_next;
  logic [9:0]  rom_q = '0;
  logic [3:0]  acc_w, b_w, r2, r3;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pat_fetch_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pc_i(pc), .acc_i(acc),
    .b_i(b), .carry_i(carry), .p_i(p), .rom_en_o(rom_en), .rom_addr_o(rom_addr),
    .rom_data_i(rom_q), .ab_we_o(ab_we), .acc_o(acc_w), .b_o(b_w),
    .io_we_o(io_we), .r2_o(r2), .r3_o(r3), .pc_we_o(pc_we),
    .pc_next_o(pc_next), .done_o(done), .busy_o(busy)
  );

  // ROM model: command bits from the offset's low pair, data from upper bits
  function automatic logic [9:0] rom_fn(input logic [11:0] a);
    return {a[1:0], a[9:2] ^ {6'b0, a[11:10]}};
  endfunction

  always_ff @(posedge clk) if (rom_en) rom_q <= rom_fn(rom_addr);

  function automatic logic [11:0] exp_addr(input logic [23:0] v);
    logic [11:0] vpc; logic [3:0] va, vb; logic vc; logic [2:0] vp;
    {vpc, va, vb, vc, vp} = v;
    return {vpc[11] | vp[2], vpc[10:6] | {vp[1:0], vc, vb[3:2]}, va, vb[1:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [23:0] v, input bit hold);
    logic [11:0] ea; logic [9:0] w;
    ea = exp_addr(v);
    w  = rom_fn(ea);
    @(negedge clk);
    {pc, acc, b, carry, p} = v;
    start = 1;
    @(negedge clk);
    check("R1 offset", 32'(rom_addr[5:0]), 32'(ea[5:0]));
    check("R2 page", 32'(rom_addr[10:6]), 32'(ea[10:6]));
    check("R3 bank", 32'(rom_addr[11]), 32'(ea[11]));
    check("R4 rom_en", 32'(rom_en), 32'd1);
    check("R8 pc_we early", 32'(pc_we), 32'd0);
    check("R7 no early write", 32'({ab_we, io_we}), 32'd0);
    if (hold) begin acc = ~acc; b = ~b; p = ~p; end
    else start = 0;
    @(negedge clk);
    check("R4 rom_en single", 32'(rom_en), 32'd0);
    check("R8 done", 32'(done), 32'd1);
    check("R8 pc_we", 32'(pc_we), 32'd1);
    check("R8 pc_next", 32'(pc_next), 32'((v[23:12] + 12'd1) & 12'hFFF));
    check("R5 ab_we", 32'(ab_we), 32'(w[8]));
    check("R6 io_we", 32'(io_we), 32'(w[9]));
    check("R7 none", 32'(!w[9] && !w[8] && (ab_we || io_we)), 32'd0);
    if (w[8]) begin
      check("R5 acc", 32'(acc_w), 32'(w[3:0]));
      check("R5 b", 32'(b_w), 32'(w[7:4]));
    end
    if (w[9]) begin
      check("R6 r2", 32'(r2), 32'(w[3:0]));
      check("R6 r3", 32'(r3), 32'(w[7:4]));
    end
    if (hold) check("R9 addr kept", 32'(rom_addr), 32'(ea));
    @(negedge clk);
    check("R9 idle after", 32'(busy), 32'd0);
    check("R8 done cleared", 32'(done), 32'd0);
    start = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 busy in reset", 32'(busy), 32'd0);
    check("R10 strobes in reset", 32'({rom_en, done, pc_we, ab_we, io_we}), 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R10 after release", 32'({busy, rom_en, done, pc_we, ab_we, io_we}), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // R9: start held high through fetch and capture
    run_vec({12'h123, 4'h6, 4'b0011, 1'b0, 3'b000}, 1'b1);
    // R3: bank 1 stays in bank 1 with p[2]=0
    run_vec({12'h801, 4'h1, 4'b0000, 1'b0, 3'b000}, 1'b0);
    // R7: both command bits clear
    run_vec({12'h000, 4'h2, 4'b0000, 1'b0, 3'b000}, 1'b0);

    // R10: reset during a fetch
    @(negedge clk);
    pc = 12'h010; start = 1;
    @(negedge clk);
    start = 0;
    rst_n = 0;
    @(negedge clk);
    check("R10 mid-fetch reset", 32'({busy, rom_en, done, pc_we, ab_we, io_we}), 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R10 stays idle", 32'(busy), 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule